// File: doc/BRIEF.md
# Omega Network Routing Fabric

This block steers up to eight packets per cycle from eight input ports to eight output ports through a three-stage multistage network. Each stage is a column of 2x2 switching elements. A perfect-shuffle wiring pattern comes before each stage: line `i` feeds the line whose index is `i` rotated left by one bit. Each input port presents a valid flag, a 3-bit destination index and a data word. The fabric tags each packet with its source port number. It then routes the packet by its destination bits, most significant bit first.

The fabric is blocking. When both packets at a switch ask for the same switch output, the packet on the upper input goes through. The packet on the lower input is dropped, and a blocked flag is raised for the input port it came from. The routing logic is combinational and feeds one register stage, so results appear one cycle after the inputs. Retrying blocked packets is the job of the logic around the fabric.

Top module: `omega_fabric`

## Requirements
- R1: While `rst` is high at a clock edge, every bit of `out_valid` and `in_blocked` is 0 after that edge.
- R2: A packet presented alone on input `s` with destination `d` appears at output `d` one cycle later, with `out_data` equal to its data and `out_src` equal to `s`, for every pair `s`, `d`.
- R3: The outputs show only inputs sampled at the previous clock edge. A packet driven in cycle t is not visible before the edge that ends cycle t.
- R4: A set of packets that needs no shared switch output, such as the identity map or the map `d = s + 3 mod 8`, is delivered in full, and no blocked flag is raised.
- R5: When two packets at a switch ask for the same output, the one on the upper input (even line) wins. For example, with 2 routed to 7 and 6 routed to 4 in the same cycle, 2 reaches output 7, input 6 is flagged blocked, and output 4 stays invalid.
- R6: With any mix of traffic, including two packets for the same destination, each output carries exactly the packet that the shuffle-and-switch rules deliver. Stage k steers on destination bit 2-k: 0 selects the upper (even) output and 1 selects the lower (odd) output.
- R7: An input whose valid flag is 0 has no effect, whatever its destination and data. With all inputs invalid, all outputs and blocked flags are 0 one cycle later.
- R8: `in_blocked[s]` is 1 one cycle after input `s` presented a valid packet that lost at some switch. Otherwise it is 0.
- R9: A valid packet leaving the last stage is on the line whose index equals its destination.
- R10: One cycle after any input pattern, the number of valid outputs plus the number of blocked flags equals the number of valid inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 8 | Packet present, one bit per input port |
| in_dst | input | 24 | 3-bit destination per input, port `i` at bits `[3i+2:3i]` |
| in_data | input | 128 | 16-bit payload per input, port `i` at bits `[16i+15:16i]` |
| out_valid | output | 8 | Packet delivered, one bit per output port |
| out_data | output | 128 | Delivered payload, port `k` at bits `[16k+15:16k]` |
| out_src | output | 24 | Source port index of the delivered packet, port `k` at bits `[3k+2:3k]` |
| in_blocked | output | 8 | Per-input flag: the packet from this input lost a conflict |

## Verification
Every result of the fabric, including delivery, source tag, data and blocked flags, is due exactly one clock edge after the input pattern that caused it. The bench drives each pattern on a falling edge and compares all outputs on the next falling edge, after exactly one rising edge. For the latency requirement, it also reads the outputs right after driving a new pattern, before any rising edge, and expects the previous idle state there. The expected delivery and blocking are worked out by a bench function that follows the shuffle, steering and upper-wins rules.

// File: rtl/omega_pkg.sv
package omega_pkg;

  // Perfect-shuffle destination: rotate a BITS-wide index left by one.
  function automatic int shuffle_dst(input int idx, input int bits);
    int top_bit;
    int mask;
    mask    = (1 << bits) - 1;
    top_bit = (idx >> (bits - 1)) & 1;
    return ((idx << 1) | top_bit) & mask;
  endfunction

endpackage

// File: rtl/omega_switch2x2.sv
module omega_switch2x2 #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  parameter int SEL_BIT = 2,
  localparam int PKT_W  = 1 + 2 * ADDR_W + DATA_W
) (
  input  logic [PKT_W-1:0]  a_in,
  input  logic [PKT_W-1:0]  b_in,
  output logic [PKT_W-1:0]  up_out,
  output logic [PKT_W-1:0]  lo_out,
  output logic              lose,
  output logic [ADDR_W-1:0] lose_src
);
  localparam int SRC_LSB = DATA_W;
  localparam int DST_LSB = DATA_W + ADDR_W;

  logic a_v, b_v, a_dir, b_dir;

  assign a_v   = a_in[PKT_W-1];
  assign b_v   = b_in[PKT_W-1];
  assign a_dir = a_in[DST_LSB + SEL_BIT];
  assign b_dir = b_in[DST_LSB + SEL_BIT];

  always_comb begin
    up_out   = '0;
    lo_out   = '0;
    lose     = 1'b0;
    lose_src = b_in[SRC_LSB +: ADDR_W];
    // Upper input has priority.
    if (a_v) begin
      if (a_dir) lo_out = a_in;
      else       up_out = a_in;
    end
    if (b_v) begin
      if (a_v && (a_dir == b_dir)) lose = 1'b1;
      else if (b_dir)              lo_out = b_in;
      else                         up_out = b_in;
    end
  end

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int N_PORTS = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  parameter int STAGE   = 0,
  localparam int PKT_W  = 1 + 2 * ADDR_W + DATA_W,
  localparam int N_SW   = N_PORTS / 2
) (
  input  logic [N_PORTS*PKT_W-1:0] lanes_in,
  output logic [N_PORTS*PKT_W-1:0] lanes_out,
  output logic [N_SW-1:0]          lose,
  output logic [N_SW*ADDR_W-1:0]   lose_src
);
  localparam int SEL_BIT = ADDR_W - 1 - STAGE;

  logic [N_PORTS*PKT_W-1:0] shuffled;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_shuffle
    localparam int J = omega_pkg::shuffle_dst(i, ADDR_W);
    assign shuffled[J*PKT_W +: PKT_W] = lanes_in[i*PKT_W +: PKT_W];
  end

  for (genvar w = 0; w < N_SW; w++) begin : g_sw
    omega_switch2x2 #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SEL_BIT(SEL_BIT)
    ) u_sw (
      .a_in    (shuffled[(2*w)*PKT_W +: PKT_W]),
      .b_in    (shuffled[(2*w+1)*PKT_W +: PKT_W]),
      .up_out  (lanes_out[(2*w)*PKT_W +: PKT_W]),
      .lo_out  (lanes_out[(2*w+1)*PKT_W +: PKT_W]),
      .lose    (lose[w]),
      .lose_src(lose_src[w*ADDR_W +: ADDR_W])
    );
  end

endmodule

// File: rtl/omega_out_reg.sv
module omega_out_reg #(
  parameter int N_PORTS = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  localparam int PKT_W  = 1 + 2 * ADDR_W + DATA_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PORTS*PKT_W-1:0]  lanes,
  input  logic [N_PORTS-1:0]        blk_next,
  output logic [N_PORTS-1:0]        out_valid,
  output logic [N_PORTS*DATA_W-1:0] out_data,
  output logic [N_PORTS*ADDR_W-1:0] out_src,
  output logic [N_PORTS-1:0]        in_blocked
);
  localparam int SRC_LSB = DATA_W;
  localparam int DST_LSB = DATA_W + ADDR_W;

  for (genvar k = 0; k < N_PORTS; k++) begin : g_lane
    logic [PKT_W-1:0]  pkt;
    logic [ADDR_W-1:0] pkt_dst;
    assign pkt     = lanes[k*PKT_W +: PKT_W];
    assign pkt_dst = pkt[DST_LSB +: ADDR_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid[k]                 <= 1'b0;
        out_data[k*DATA_W +: DATA_W] <= '0;
        out_src[k*ADDR_W +: ADDR_W]  <= '0;
        in_blocked[k]                <= 1'b0;
      end else begin
        out_valid[k]                 <= pkt[PKT_W-1];
        out_data[k*DATA_W +: DATA_W] <= pkt[DATA_W-1:0];
        out_src[k*ADDR_W +: ADDR_W]  <= pkt[SRC_LSB +: ADDR_W];
        in_blocked[k]                <= blk_next[k];
      end
    end

    // R9: a packet leaving the last stage sits on its destination line.
    p_dest_line_r9: assert property (@(posedge clk) disable iff (rst)
      pkt[PKT_W-1] |-> (pkt_dst == ADDR_W'(k)));
  end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int N_PORTS = 8,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_PORTS-1:0]        in_valid,
  input  logic [N_PORTS*ADDR_W-1:0] in_dst,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  output logic [N_PORTS-1:0]        out_valid,
  output logic [N_PORTS*DATA_W-1:0] out_data,
  output logic [N_PORTS*ADDR_W-1:0] out_src,
  output logic [N_PORTS-1:0]        in_blocked
);
  localparam int PKT_W  = 1 + 2 * ADDR_W + DATA_W;
  localparam int STAGES = ADDR_W;
  localparam int N_SW   = N_PORTS / 2;
  localparam int N_LOSE = STAGES * N_SW;

  logic [N_PORTS*PKT_W-1:0] lanes [STAGES+1];
  logic [N_LOSE-1:0]        lose_all;
  logic [N_LOSE*ADDR_W-1:0] lose_src_all;
  logic [N_PORTS-1:0]       blk_next;

  // Tag each input with its own port index as source.
  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    assign lanes[0][i*PKT_W +: PKT_W] = {in_valid[i],
                                         in_dst[i*ADDR_W +: ADDR_W],
                                         ADDR_W'(i),
                                         in_data[i*DATA_W +: DATA_W]};
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    omega_stage #(
      .N_PORTS(N_PORTS),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .STAGE  (s)
    ) u_stage (
      .lanes_in (lanes[s]),
      .lanes_out(lanes[s+1]),
      .lose     (lose_all[s*N_SW +: N_SW]),
      .lose_src (lose_src_all[s*N_SW*ADDR_W +: N_SW*ADDR_W])
    );
  end

  always_comb begin
    blk_next = '0;
    for (int j = 0; j < N_LOSE; j++) begin
      if (lose_all[j]) blk_next[lose_src_all[j*ADDR_W +: ADDR_W]] = 1'b1;
    end
  end

  omega_out_reg #(
    .N_PORTS(N_PORTS),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .lanes     (lanes[STAGES]),
    .blk_next  (blk_next),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_src   (out_src),
    .in_blocked(in_blocked)
  );

  // R1: reset clears valid and blocked outputs.
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (out_valid == '0 && in_blocked == '0));

  // R7: an all-idle input cycle yields all-idle outputs.
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid == '0) |=> (out_valid == '0 && in_blocked == '0));

  // R8: only an input that carried a packet can be flagged blocked.
  p_blk_needs_pkt_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid != '0) |=> ((in_blocked & ~$past(in_valid)) == '0));

  // R10: every valid input is either delivered or blocked.
  p_conserve_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid != '0) |=>
      ($countones(out_valid) + $countones(in_blocked) == $countones($past(in_valid))));

endmodule

// File: tb/tb_omega_fabric.sv
module tb_omega_fabric;
  localparam int N  = 8;
  localparam int A  = 3;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    in_valid = '0;
  logic [N*A-1:0]  in_dst = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    out_valid;
  logic [N*DW-1:0] out_data;
  logic [N*A-1:0]  out_src;
  logic [N-1:0]    in_blocked;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  logic [N-1:0] exp_v;
  logic [A-1:0] exp_src [N];
  logic [N-1:0] exp_blk;

  always #5 clk = ~clk;

  omega_fabric #(.N_PORTS(N), .ADDR_W(A), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_src(out_src), .in_blocked(in_blocked)
  );

  function automatic int rot1(input int i);
    return ((i << 1) | (i >> (A - 1))) & (N - 1);
  endfunction

  // Expected outcome from the shuffle, steering and upper-wins rules.
  task automatic model();
    logic       lv [N];
    logic [A-1:0] ls [N];
    logic [A-1:0] ld [N];
    logic       nv [N];
    logic [A-1:0] ns [N];
    logic [A-1:0] nd [N];
    exp_blk = '0;
    for (int i = 0; i < N; i++) begin
      lv[i] = in_valid[i]; ls[i] = A'(i); ld[i] = in_dst[i*A +: A];
    end
    for (int s = 0; s < A; s++) begin
      for (int i = 0; i < N; i++) begin
        nv[rot1(i)] = lv[i]; ns[rot1(i)] = ls[i]; nd[rot1(i)] = ld[i];
      end
      for (int i = 0; i < N; i++) lv[i] = 1'b0;
      for (int w = 0; w < N/2; w++) begin
        int u;
        int b;
        logic pu;
        logic pb;
        u = 2*w; b = 2*w + 1;
        pu = nd[u][A-1-s];
        pb = nd[b][A-1-s];
        if (nv[u]) begin
          lv[pu ? b : u] = 1'b1; ls[pu ? b : u] = ns[u]; ld[pu ? b : u] = nd[u];
        end
        if (nv[b]) begin
          if (nv[u] && pu == pb) exp_blk[ns[b]] = 1'b1;
          else begin
            lv[pb ? b : u] = 1'b1; ls[pb ? b : u] = ns[b]; ld[pb ? b : u] = nd[b];
          end
        end
      end
    end
    for (int k = 0; k < N; k++) begin
      exp_v[k] = lv[k]; exp_src[k] = ls[k];
    end
  endtask

  task automatic compare(input string tag);
    int nin;
    int nout;
    for (int k = 0; k < N; k++) begin
      logic [DW-1:0] ed;
      checks++;
      if (out_valid[k] !== exp_v[k]) begin
        bad++;
        $display("FAIL %s out_valid[%0d] actual=%b expected=%b", tag, k, out_valid[k], exp_v[k]);
      end else if (exp_v[k]) begin
        ed = in_data[exp_src[k]*DW +: DW];
        if (out_src[k*A +: A] !== exp_src[k] || out_data[k*DW +: DW] !== ed) begin
          bad++;
          $display("FAIL %s port %0d actual src=%0d data=%h expected src=%0d data=%h",
                   tag, k, out_src[k*A +: A], out_data[k*DW +: DW], exp_src[k], ed);
        end
      end
    end
    checks++;
    if (in_blocked !== exp_blk) begin
      bad++;
      $display("FAIL %s/R8 in_blocked actual=%b expected=%b", tag, in_blocked, exp_blk);
    end
    // R10: delivered plus blocked equals offered
    nin = $countones(in_valid);
    nout = $countones(out_valid) + $countones(in_blocked);
    checks++;
    if (nin != nout) begin
      bad++;
      $display("FAIL R10 conservation actual=%0d expected=%0d", nout, nin);
    end
  endtask

  // Called at a falling edge: drive, wait one rising edge, check.
  task automatic apply(input logic [N-1:0] v, input logic [N*A-1:0] d,
                       input logic [N*DW-1:0] x, input string tag);
    in_valid = v; in_dst = d; in_data = x;
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_dst(inout logic [N*A-1:0] d, input int port, input int val);
    d[port*A +: A] = A'(val);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [N*A-1:0]  d;
    logic [N*DW-1:0] x;
    void'($urandom(32'h0E6A5));
    // R1: reset with busy inputs
    in_valid = '1;
    for (int i = 0; i < N; i++) begin
      in_dst[i*A +: A] = A'(i); in_data[i*DW +: DW] = DW'(16'hA000 + i);
    end
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== '0 || in_blocked !== '0) begin
      bad++;
      $display("FAIL R1 reset actual valid=%b blk=%b expected 0/0", out_valid, in_blocked);
    end
    rst = 1'b0;
    in_valid = '0;
    @(negedge clk);

    // R2: every single source to every destination
    for (int s = 0; s < N; s++) begin
      for (int t = 0; t < N; t++) begin
        d = '0;
        x = '0;
        set_dst(d, s, t);
        x[s*DW +: DW] = DW'(s * 256 + t * 17 + 5);
        apply(N'(1) << s, d, x, "R2");
      end
    end

    // R3: a fresh packet is invisible before the rising edge
    apply('0, '0, '0, "R7");
    d = '0;
    set_dst(d, 3, 5);
    x = '0;
    x[3*DW +: DW] = 16'h3355;
    in_valid = N'(1) << 3; in_dst = d; in_data = x;
    #1;
    checks++;
    if (out_valid !== '0) begin
      bad++;
      $display("FAIL R3 early output actual=%b expected=%b", out_valid, {N{1'b0}});
    end
    model();
    @(negedge clk);
    compare("R3");

    // R4: identity and shift-by-three permutations
    d = '0;
    for (int i = 0; i < N; i++) begin
      set_dst(d, i, i); x[i*DW +: DW] = DW'(16'h1100 + i);
    end
    apply('1, d, x, "R4");
    d = '0;
    for (int i = 0; i < N; i++) set_dst(d, i, (i + 3) % N);
    apply('1, d, x, "R4");
    checks++;
    if (in_blocked !== '0) begin
      bad++;
      $display("FAIL R4 no blocking actual=%b expected=%b", in_blocked, {N{1'b0}});
    end

    // R5: 2->7 and 6->4 share a link, upper input 2 wins
    d = '0;
    set_dst(d, 2, 7);
    set_dst(d, 6, 4);
    apply((N'(1) << 2) | (N'(1) << 6), d, x, "R5");
    checks++;
    if (!(out_valid[7] && out_src[7*A +: A] == 3'd2 && in_blocked == 8'h40 && !out_valid[4])) begin
      bad++;
      $display("FAIL R5 actual valid=%b blk=%b expected valid[7]=1 blk=01000000",
               out_valid, in_blocked);
    end

    // R6: 0 and 4 both to 0, input 0 wins
    d = '0;
    apply((N'(1) << 0) | (N'(1) << 4), d, x, "R6");
    checks++;
    if (in_blocked !== 8'h10 || out_src[2:0] !== 3'd0) begin
      bad++;
      $display("FAIL R6 same-dest actual blk=%b src=%0d expected blk=00010000 src=0",
               in_blocked, out_src[2:0]);
    end

    // R7: invalid inputs with conflicting destinations do nothing
    d = '0;
    apply('0, d, x, "R7");
    apply(8'h01, d, x, "R7");

    // R6/R8/R10: random traffic
    for (int n = 0; n < 400; n++) begin
      logic [N-1:0] v;
      v = N'($urandom);
      for (int i = 0; i < N; i++) begin
        set_dst(d, i, int'($urandom % N));
        x[i*DW +: DW] = DW'($urandom);
      end
      apply(v, d, x, "R6");
    end

    apply('0, '0, '0, "R7");
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule